// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial flash command at a time over a single-bit, half-duplex SPI link in mode 3. Software loads an address word and, for writes, a data word. It then writes a command word that packs the opcode, the address length, the dummy length, the data length, the direction, a chip-select index and a keep-selected flag. The engine drives chip select low and shifts out the opcode, the address and the dummy bytes. It then either sends up to four data bytes or collects up to four bytes from the flash.

A flash transaction longer than four data bytes is built from a chain of commands. A command with keep-selected set leaves chip select low when it finishes. The next command then continues the same transaction: it sends no opcode, and normally carries zero address and dummy length. A final command with the flag clear releases chip select. A command with a zero data count only ends the transaction.

A small word-addressed register bus gives access to the command, address, data, status and I/O-level registers. Status shows a busy bit and an error bit. The error bit is set when a command is written while the engine is still busy.

Top module: `sfe_engine`

## Requirements
- R1: Register word index 0 is status, 1 is command, 2 is address (bits 23:0), 3 is data and 4 is I/O level (bits 3:0). After reset, status reads 0, I/O level reads 4'hF, every chip select is high and sck is high.
- R2: The command fields are: opcode bits 7:0, write flag bit 8, data count bits 11:9, keep-selected bit 15, dummy count bits 19:16, address count bits 22:20 and chip-select index bits 26:24. A data count above 4 acts as 4, and an address count above 3 acts as 3.
- R3: A command that starts a transaction pulls csN[index] low. It sends the opcode first, then the low address-count bytes of the address register, most significant byte first.
- R4: Dummy bytes follow the address and are sent as zero. The miso line is ignored while they are sent.
- R5: A write command sends data-register byte 0 (bits 7:0) first, followed by the higher bytes in order.
- R6: A read command places the first byte received in data bits 7:0 and later bytes in higher bytes. Each byte is received MSB first. Bytes above the data count read as zero.
- R7: With keep-selected set, chip select stays low after the command ends. The next command sends no opcode, only its address, dummy and data bytes.
- R8: With keep-selected clear, chip select rises in the same cycle that busy clears. A zero-data command issued while chip select is held sends no bits and only releases chip select.
- R9: Status bit 22 reads 1 from the cycle after an accepted command write until that command ends. Read data is valid once the bit clears.
- R10: A command write while status bit 22 is set has no effect and sets status bit 29. Writing 1 to bit 29 of status clears it.
- R11: Mode 3: sck idles high and toggles only while a chip select is low. mosi changes after the falling edge, and miso is sampled at the rising edge. At most one chip select is low at a time.
- R12: I/O level bit 0 sets the level of mosi while no bits are being shifted. Bit 2 drives wpN and bit 3 drives holdN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 3 | Register word index |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| sck | output | 1 | Serial clock, idles high |
| csN | output | NUM_CS | Chip selects, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| wpN | output | 1 | Write-protect line level |
| holdN | output | 1 | Hold line level |

## Verification
The bench goes after the chained transaction. It checks that a continuation command resends no opcode. A design that gets this wrong inserts a stray byte into the flash stream. The bench also checks that a zero-data closing command shifts nothing and still raises chip select, and that the received-data byte position follows the byte count on the wire. A flash model returns a different byte in every position, including the dummy slots. A design that captured miso during dummy bytes, or that packed received bytes in the wrong order, would show the wrong data word. Out-of-range length fields and a command written while busy are also exercised. A design that did not clamp the lengths would send a wrong byte count. One that accepted the early command would corrupt the command register and the stream.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;
  // register word indices
  localparam logic [2:0] RA_STAT = 3'd0;
  localparam logic [2:0] RA_CMD  = 3'd1;
  localparam logic [2:0] RA_ADDR = 3'd2;
  localparam logic [2:0] RA_DATA = 3'd3;
  localparam logic [2:0] RA_LVL  = 3'd4;

  localparam int BIT_BUSY = 22;
  localparam int BIT_ERR  = 29;
  localparam int MAX_ADDR_BYTES = 3;
  localparam int MAX_DATA_BYTES = 4;

  typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DUM, PH_DATA} phase_t;

  // sequencing fields of a command, after clamping
  typedef struct packed {
    logic       wr;
    logic [2:0] dlen;
    logic       keep;
    logic [3:0] dum;
    logic [1:0] alen;
  } seq_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       loadTx;
    phase_t     src;
    logic [3:0] idx;
    logic       shiftTx;
    logic       sampleRx;
    logic       storeRx;
    logic [1:0] rxIdx;
    logic       csOff;
  } strobe_t;

  function automatic seq_t decodeSeq(input logic [31:0] w);
    seq_t s;
    s.wr   = w[8];
    s.dlen = (w[11:9] > 3'(MAX_DATA_BYTES)) ? 3'(MAX_DATA_BYTES) : w[11:9];
    s.keep = w[15];
    s.dum  = w[19:16];
    s.alen = (w[22:20] > 3'(MAX_ADDR_BYTES)) ? 2'(MAX_ADDR_BYTES) : w[21:20];
    return s;
  endfunction
endpackage

// File: rtl/sfe_ctrl.sv
`timescale 1ns/1ps
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  seq_t    newSeq,
  input  logic    csHeld,
  output strobe_t strb,
  output logic    busy,
  output logic    shifting,
  output logic    sck
);
  localparam int HC_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PICK, S_SHIFT, S_HOLD} state_t;

  state_t      state;
  phase_t      phase;
  seq_t        curSeq;
  logic        skipOpc;
  logic [3:0]  byteIdx;
  logic [2:0]  bitIdx;
  logic        bitHigh;
  logic [HC_W-1:0] halfCnt;
  logic        halfDone;
  logic        nxtFound;
  phase_t      nxtPhase;
  logic [3:0]  curLen;
  logic        lastByte;
  int          fromIdx;

  function automatic logic [3:0] phLen(input int p, input seq_t s, input logic skip);
    case (p)
      0:       return skip ? 4'd0 : 4'd1;
      1:       return {2'b00, s.alen};
      2:       return s.dum;
      default: return {1'b0, s.dlen};
    endcase
  endfunction

  assign halfDone = (halfCnt == HC_W'(SCK_HALF - 1));
  assign curLen   = phLen(int'(phase), curSeq, skipOpc);
  assign lastByte = !(4'(byteIdx + 4'd1) < curLen);
  assign fromIdx  = (state == S_PICK) ? -1 : int'(phase);

  // next phase with a non-zero byte count
  always_comb begin
    nxtFound = 1'b0;
    nxtPhase = PH_OPC;
    for (int k = 0; k < 4; k++) begin
      if (!nxtFound && k > fromIdx && phLen(k, curSeq, skipOpc) != 4'd0) begin
        nxtFound = 1'b1;
        nxtPhase = phase_t'(2'(k));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= PH_OPC;
      curSeq  <= '0;
      skipOpc <= 1'b0;
      byteIdx <= '0;
      bitIdx  <= '0;
      bitHigh <= 1'b0;
      halfCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            curSeq  <= newSeq;
            skipOpc <= csHeld;
            halfCnt <= '0;
            state   <= csHeld ? S_PICK : S_SETUP;
          end
        end
        S_SETUP: begin
          if (halfDone) begin
            halfCnt <= '0;
            state   <= S_PICK;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        S_PICK: begin
          bitIdx  <= '0;
          bitHigh <= 1'b0;
          halfCnt <= '0;
          byteIdx <= '0;
          if (nxtFound) begin
            phase <= nxtPhase;
            state <= S_SHIFT;
          end else begin
            state <= S_HOLD;
          end
        end
        S_SHIFT: begin
          if (!halfDone) begin
            halfCnt <= halfCnt + 1'b1;
          end else begin
            halfCnt <= '0;
            if (!bitHigh) begin
              bitHigh <= 1'b1;
            end else begin
              bitHigh <= 1'b0;
              if (bitIdx != 3'd7) begin
                bitIdx <= bitIdx + 3'd1;
              end else begin
                bitIdx <= '0;
                if (!lastByte) begin
                  byteIdx <= byteIdx + 4'd1;
                end else if (nxtFound) begin
                  phase   <= nxtPhase;
                  byteIdx <= '0;
                end else begin
                  state <= S_HOLD;
                end
              end
            end
          end
        end
        S_HOLD: begin
          if (halfDone) begin
            halfCnt <= '0;
            state   <= S_IDLE;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    case (state)
      S_PICK: begin
        if (nxtFound) begin
          strb.loadTx = 1'b1;
          strb.src    = nxtPhase;
          strb.idx    = 4'd0;
        end
      end
      S_SHIFT: begin
        if (halfDone) begin
          if (!bitHigh) begin
            strb.sampleRx = 1'b1;
          end else if (bitIdx != 3'd7) begin
            strb.shiftTx = 1'b1;
          end else begin
            if (phase == PH_DATA && !curSeq.wr) begin
              strb.storeRx = 1'b1;
              strb.rxIdx   = byteIdx[1:0];
            end
            if (!lastByte) begin
              strb.loadTx = 1'b1;
              strb.src    = phase;
              strb.idx    = byteIdx + 4'd1;
            end else if (nxtFound) begin
              strb.loadTx = 1'b1;
              strb.src    = nxtPhase;
              strb.idx    = 4'd0;
            end
          end
        end
      end
      S_HOLD: strb.csOff = halfDone && !curSeq.keep;
      default: ;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign shifting = (state == S_SHIFT);
  assign sck      = !(shifting && !bitHigh);
endmodule

// File: rtl/sfe_dpath.sv
`timescale 1ns/1ps
module sfe_dpath
  import sfe_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              busy,
  input  logic              shifting,
  input  strobe_t           strb,
  input  logic              miso,
  output logic              start,
  output seq_t              newSeq,
  output logic              csHeld,
  output logic [NUM_CS-1:0] csN,
  output logic              mosi,
  output logic              wpN,
  output logic              holdN,
  output logic              errFlag
);
  localparam int CS_IDX_W = 3;

  logic [31:0] cmdReg;
  logic [31:0] dataReg;
  logic [23:0] addrReg;
  logic [3:0]  lvlReg;
  logic [7:0]  txByte;
  logic [7:0]  rxByte;
  logic [7:0]  txNext;
  logic        csActive;
  logic [CS_IDX_W-1:0] csIdx;
  logic        cmdWr;
  logic [1:0]  liveAlen;

  assign cmdWr    = regWe && (regAddr == RA_CMD);
  assign start    = cmdWr && !busy;
  assign newSeq   = decodeSeq(regWdata);
  assign liveAlen = (cmdReg[22:20] > 3'(MAX_ADDR_BYTES)) ? 2'(MAX_ADDR_BYTES) : cmdReg[21:20];

  // byte to shift next
  always_comb begin
    txNext = 8'h00;
    case (strb.src)
      PH_OPC:  txNext = cmdReg[7:0];
      PH_ADDR: txNext = 8'(addrReg >> (8 * (int'(liveAlen) - 1 - int'(strb.idx))));
      PH_DUM:  txNext = 8'h00;
      default: txNext = cmdReg[8] ? 8'(dataReg >> (8 * int'(strb.idx[1:0]))) : 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      dataReg  <= '0;
      addrReg  <= '0;
      lvlReg   <= 4'hF;
      txByte   <= '0;
      rxByte   <= '0;
      csActive <= 1'b0;
      csIdx    <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (start) begin
        cmdReg <= regWdata;
        if (!newSeq.wr) dataReg <= '0;
        if (!csActive) begin
          csActive <= 1'b1;
          csIdx    <= regWdata[24 +: CS_IDX_W];
        end
      end
      if (cmdWr && busy) errFlag <= 1'b1;
      else if (regWe && regAddr == RA_STAT && regWdata[BIT_ERR]) errFlag <= 1'b0;
      if (regWe && !busy) begin
        case (regAddr)
          RA_ADDR: addrReg <= regWdata[23:0];
          RA_DATA: dataReg <= regWdata;
          default: ;
        endcase
      end
      if (regWe && regAddr == RA_LVL) lvlReg <= regWdata[3:0];
      if (strb.loadTx)       txByte <= txNext;
      else if (strb.shiftTx) txByte <= {txByte[6:0], 1'b0};
      if (strb.sampleRx) rxByte <= {rxByte[6:0], miso};
      if (strb.storeRx)  dataReg[8 * strb.rxIdx +: 8] <= rxByte;
      if (strb.csOff)    csActive <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = !(csActive && int'(csIdx) == i);
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      RA_STAT: begin
        regRdata[BIT_BUSY] = busy;
        regRdata[BIT_ERR]  = errFlag;
      end
      RA_CMD:  regRdata = cmdReg;
      RA_ADDR: regRdata = {8'h00, addrReg};
      RA_DATA: regRdata = dataReg;
      RA_LVL:  regRdata = {28'h0, lvlReg};
      default: regRdata = '0;
    endcase
  end

  assign csHeld = csActive;
  assign mosi   = shifting ? txByte[7] : lvlReg[0];
  assign wpN    = lvlReg[2];
  assign holdN  = lvlReg[3];
endmodule

// File: rtl/sfe_engine.sv
`timescale 1ns/1ps
module sfe_engine
  import sfe_pkg::*;
#(
  parameter int NUM_CS   = 8,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              sck,
  output logic [NUM_CS-1:0] csN,
  output logic              mosi,
  input  logic              miso,
  output logic              wpN,
  output logic              holdN
);
  strobe_t strb;
  seq_t    newSeq;
  logic    start;
  logic    busyFlag;
  logic    shifting;
  logic    csHeld;
  logic    errFlag;

  sfe_ctrl #(.SCK_HALF(SCK_HALF)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .newSeq   (newSeq),
    .csHeld   (csHeld),
    .strb     (strb),
    .busy     (busyFlag),
    .shifting (shifting),
    .sck      (sck)
  );

  sfe_dpath #(.NUM_CS(NUM_CS)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .busy     (busyFlag),
    .shifting (shifting),
    .strb     (strb),
    .miso     (miso),
    .start    (start),
    .newSeq   (newSeq),
    .csHeld   (csHeld),
    .csN      (csN),
    .mosi     (mosi),
    .wpN      (wpN),
    .holdN    (holdN),
    .errFlag  (errFlag)
  );
endmodule

// File: rtl/sfe_checker.sv
`timescale 1ns/1ps
module sfe_checker
  import sfe_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        regAddr,
  input logic              regWe,
  input logic              errClrBit,
  input logic              sck,
  input logic [NUM_CS-1:0] csN,
  input logic              wpN,
  input logic              holdN,
  input logic              busyFlag,
  input logic              errFlag
);
  assert_cs_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_sck_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> sck);

  assert_busy_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == RA_CMD && !busyFlag) |=> busyFlag);

  assert_reject_err_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == RA_CMD && busyFlag) |=> errFlag);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == RA_STAT && errClrBit) |=> !errFlag);

  assert_pins_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == RA_LVL) |=> $stable({wpN, holdN}));

  assert_release_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(&csN) |-> $fell(busyFlag));
endmodule

bind sfe_engine sfe_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWe     (regWe),
  .errClrBit (regWdata[29]),
  .sck       (sck),
  .csN       (csN),
  .wpN       (wpN),
  .holdN     (holdN),
  .busyFlag  (busyFlag),
  .errFlag   (errFlag)
);

// File: tb/sfe_engine_bench.sv
`timescale 1ns/1ps
module sfe_engine_bench;
  import sfe_pkg::*;
  localparam int NUM_CS = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        regAddr = '0;
  logic              regWe = 1'b0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              sck;
  logic [NUM_CS-1:0] csN;
  logic              mosi;
  logic              miso = 1'b1;
  logic              wpN;
  logic              holdN;

  sfe_engine #(.NUM_CS(NUM_CS), .SCK_HALF(2)) u_sfe_engine (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .wpN(wpN), .holdN(holdN)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // flash model: logs mosi bytes, answers a position-dependent pattern
  logic [7:0] logBytes [0:127];
  int logCnt = 0;
  int riseCnt = 0;
  int strayEdges = 0;
  int csSeen = -1;
  logic [7:0] curIn = '0;

  function automatic logic [7:0] respByte(input int n);
    return 8'((n * 29 + 167) & 255);
  endfunction

  initial begin : flash_model
    logic csPrev;
    logic sckPrev;
    logic csAny;
    logic [7:0] r;
    int b;
    int k;
    csPrev = 1'b0;
    sckPrev = 1'b1;
    forever begin
      @(csN or sck);
      csAny = ~&csN;
      if (csAny && !csPrev) begin
        riseCnt = 0;
        logCnt = 0;
        for (int i = 0; i < NUM_CS; i++) if (!csN[i]) csSeen = i;
      end
      if (sck !== sckPrev) begin
        if (!csAny) strayEdges++;
        else if (sck) begin
          curIn = {curIn[6:0], mosi};
          riseCnt++;
          if (riseCnt % 8 == 0) begin
            if (logCnt < 128) logBytes[logCnt] = curIn;
            logCnt++;
          end
        end else begin
          b = riseCnt / 8;
          k = 7 - (riseCnt % 8);
          r = respByte(b);
          miso = r[k];
        end
      end
      csPrev = csAny;
      sckPrev = sck;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    int n;
    n = 0;
    do begin
      busRead(RA_STAT, s);
      n++;
    end while (s[BIT_BUSY] && n < 20000);
  endtask

  // bench model of the expected wire stream
  logic [7:0] expB [0:127];
  int expN = 0;
  bit held = 0;

  function automatic logic [31:0] mkWord(input logic [7:0] opc, input bit wr, input int dlenF,
      input bit keep, input int dum, input int alenF, input int cs);
    return {5'b0, 3'(cs), 1'b0, 3'(alenF), 4'(dum), keep, 3'b0, 3'(dlenF), wr, opc};
  endfunction

  task automatic checkStream(input string req);
    bit ok;
    ok = (logCnt == expN);
    for (int i = 0; i < expN && i < 128; i++) begin
      if (ok && logBytes[i] !== expB[i]) begin
        ok = 0;
        $display("FAIL %s: byte %0d actual %0h expected %0h", req, i, logBytes[i], expB[i]);
      end
    end
    chk(ok, req, 32'(logCnt), 32'(expN));
  endtask

  task automatic doCmd(input string req, input logic [7:0] opc, input bit wr, input int dlenF,
      input bit keep, input int dum, input int alenF, input int cs,
      input logic [23:0] addr, input logic [31:0] wdat);
    int al;
    int dl;
    logic [31:0] word;
    logic [31:0] rd;
    logic [31:0] expData;
    logic [NUM_CS-1:0] expCs;
    al = (alenF > 3) ? 3 : alenF;
    dl = (dlenF > 4) ? 4 : dlenF;
    expData = '0;
    word = mkWord(opc, wr, dlenF, keep, dum, alenF, cs);
    busWrite(RA_ADDR, {8'h00, addr});
    busWrite(RA_DATA, wdat);
    if (!held) begin
      expN = 0;
      expB[expN] = opc; expN++;
    end
    for (int i = 0; i < al; i++) begin expB[expN] = 8'(addr >> ((al - 1 - i) * 8)); expN++; end
    for (int i = 0; i < dum; i++) begin expB[expN] = 8'h00; expN++; end
    for (int i = 0; i < dl; i++) begin
      if (wr) expB[expN] = 8'(wdat >> (i * 8));
      else begin
        expData[i*8 +: 8] = respByte(expN);
        expB[expN] = 8'h00;
      end
      expN++;
    end
    busWrite(RA_CMD, word);
    waitIdle();
    checkStream(req);
    if (!wr) begin
      busRead(RA_DATA, rd);
      chk(rd === expData, {req, " R6 read data"}, rd, expData);
    end
    expCs = keep ? ~(NUM_CS'(1) << cs) : '1;
    chk(csN === expCs, {req, " chip select after"}, 32'(csN), 32'(expCs));
    if (!held) chk(csSeen == cs, {req, " R3 cs index"}, 32'(csSeen), 32'(cs));
    held = keep;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] s;
    logic [31:0] c;
    logic [31:0] w1;
    logic [31:0] w2;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(RA_STAT, s);
    chk(s === 32'h0, "R1 status reset", s, 32'h0);
    busRead(RA_LVL, s);
    chk(s === 32'hF, "R1 level reset", s, 32'hF);
    chk(csN === '1, "R1 cs reset", 32'(csN), 32'hFF);
    chk(sck === 1'b1, "R1 sck idle", 32'(sck), 1);
    chk(wpN === 1'b1 && holdN === 1'b1 && mosi === 1'b1, "R12 pins reset",
        {29'h0, wpN, holdN, mosi}, 32'h7);

    // directed fresh commands: R3 R4 R5 R6
    doCmd("R3/R5 write", 8'h02, 1, 4, 0, 0, 3, 2, 24'hA1B2C3, 32'h44332211);
    doCmd("R4/R6 read dummy", 8'h0B, 0, 4, 0, 2, 3, 5, 24'h123456, 32'hFFFFFFFF);
    doCmd("R6 partial read", 8'h03, 0, 2, 0, 0, 2, 0, 24'h00BEEF, 32'hDEADBEEF);
    doCmd("R8 opcode only", 8'h06, 1, 0, 0, 0, 0, 7, 24'h0, 32'h0);
    // R2 clamping: address field 7 acts as 3, data field 7 acts as 4
    doCmd("R2 clamp write", 8'h32, 1, 7, 0, 1, 7, 1, 24'h5A6B7C, 32'hCAFEF00D);
    doCmd("R2 clamp read", 8'h6B, 0, 6, 0, 0, 5, 3, 24'h010203, 32'h0);

    // R7 chained transaction, then R8 closing
    doCmd("R7 chain head", 8'h0B, 0, 4, 1, 1, 3, 4, 24'h7F0010, 32'h0);
    doCmd("R7 chain mid", 8'h0B, 0, 4, 1, 0, 0, 4, 24'h0, 32'h0);
    doCmd("R8 chain tail", 8'h0B, 0, 3, 0, 0, 0, 4, 24'h0, 32'h0);
    doCmd("R7 write head", 8'h02, 1, 2, 1, 0, 3, 6, 24'h00F00D, 32'h0000BBAA);
    doCmd("R8 end only", 8'h02, 1, 0, 0, 0, 0, 6, 24'h0, 32'h0);

    // R9 busy and R10 rejection
    w1 = mkWord(8'h3B, 0, 1, 0, 15, 3, 1);
    w2 = mkWord(8'hC7, 1, 0, 0, 0, 0, 2);
    busWrite(RA_ADDR, 32'h00ABCDEF);
    busWrite(RA_CMD, w1);
    busRead(RA_STAT, s);
    chk(s[BIT_BUSY] === 1'b1, "R9 busy set", s, 32'h400000);
    chk(s[BIT_ERR] === 1'b0, "R10 no error yet", s, 32'h400000);
    busWrite(RA_CMD, w2);
    waitIdle();
    busRead(RA_STAT, s);
    chk(s === 32'h20000000, "R10 error set and idle", s, 32'h20000000);
    busRead(RA_CMD, c);
    chk(c === w1, "R10 command kept", c, w1);
    chk(logCnt == 20, "R10 no extra bytes", 32'(logCnt), 20);
    busRead(RA_DATA, c);
    chk(c === {24'h0, respByte(19)}, "R4 dummy ignored R6", c, {24'h0, respByte(19)});
    busWrite(RA_STAT, 32'h20000000);
    busRead(RA_STAT, s);
    chk(s === 32'h0, "R10 error cleared", s, 32'h0);
    held = 0;

    // R12 level register
    busWrite(RA_LVL, 32'h2);
    @(negedge clk);
    chk({holdN, wpN, mosi} === 3'b000, "R12 levels low", {29'h0, holdN, wpN, mosi}, 0);
    busRead(RA_LVL, s);
    chk(s === 32'h2, "R12 readback", s, 32'h2);
    busWrite(RA_LVL, 32'hD);
    @(negedge clk);
    chk({holdN, wpN, mosi} === 3'b111, "R12 levels high", {29'h0, holdN, wpN, mosi}, 7);
    doCmd("R12 shift with levels", 8'h9F, 0, 3, 0, 0, 0, 0, 24'h0, 32'h0);
    busWrite(RA_LVL, 32'hF);

    // random fresh commands
    for (int n = 0; n < 30; n++) begin
      doCmd("R2/R3 random", 8'($urandom), bit'($urandom % 2), int'($urandom % 8), 0,
            int'($urandom % 16), int'($urandom % 8), int'($urandom % 8),
            24'($urandom), $urandom);
    end

    // R11 clock only while selected
    chk(strayEdges == 0, "R11 sck stray edges", 32'(strayEdges), 0);
    chk(sck === 1'b1 && csN === '1, "R11 idle at end", {23'h0, sck, csN}, 32'h1FF);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule